// File: doc/BRIEF.md
# Accumulator Machine Fetch-Execute Sequencer

This block is the control unit and datapath of a small accumulator processor that works one instruction at a time. Every memory transaction, instruction fetch included, goes through a memory address register and a memory buffer register. The fetched word is then copied from the buffer register into a separate current-instruction register. After that the sequencer decodes it, runs the execute steps, and finally checks for a pending interrupt before it starts the next fetch. Instructions never overlap.

The block drives one single-port synchronous memory. The address bus comes from the address register and the write-data bus from the buffer register. A one-cycle read strobe or write strobe forms the control bus. Read data returns one clock after the read strobe. The block carries an ALU (add, subtract, AND, OR, compare), accumulator loads and stores, moves, direct and indirect jumps, a halt instruction and one vectored interrupt. The interrupt saves the return address to a fixed word. A handler returns with an indirect jump through that word.

Top module: `acc_cpu_core`

## Requirements
- R1: While reset is high the read and write strobes and `halted_o` are low. Reset clears the program counter, the accumulator and all five status bits. The first read strobe after reset addresses word 0.
- R2: Each instruction begins with a read strobe at the program-counter address. The program counter then advances by one, and the next fetch starts only after the previous instruction's execute steps and the interrupt check are done.
- R3: `mem_addr_o` always shows the address register and `mem_wdata_o` the buffer register. A read strobe lasts one cycle and the data appears on `mem_rdata_i` the following cycle. Read and write never assert together. An ALU instruction issues exactly two reads (fetch plus operand) and no write.
- R4: STORE (opcode 0x2) asserts the write strobe for one cycle with the operand field on the address bus and the accumulator on the data bus.
- R5: ADD (0x3), SUB (0x4), AND (0x5) and OR (0x6) combine the accumulator with the memory word at the operand address. The result goes to the accumulator.
- R6: Status word bits: bit 4 interrupt pending, bit 3 overflow (signed), bit 2 carry, bit 1 zero, bit 0 negative. Add sets carry on unsigned carry-out. Subtract and compare set carry on borrow (minuend below subtrahend, unsigned). AND and OR clear carry and overflow.
- R7: CMP (0x7) updates the flags from accumulator minus memory word and leaves the accumulator unchanged.
- R8: LOAD (0x1) sets the accumulator to the memory word. LDI (0x9) sets it to the zero-extended operand field. MOVS (0xB) copies the zero-extended status word into it. None of these changes the flags.
- R9: JMP (0x8) sets the program counter to the operand field. JMPI (0xA) sets it to the low address bits of the memory word at the operand address.
- R10: A high `irq_i` sets the pending bit. When the bit is set after an execute, the block writes the program counter to SAVE_ADDR (default 0x0FF). It then clears the pending bit and fetches next from VEC_ADDR (default 0x040).
- R11: HALT (0x0) raises `halted_o` for good. After that there are no further reads or writes and interrupts are not taken, until reset.
- R12: The instruction word holds the opcode in bits 15:12 and the address or immediate operand in bits 11:0. Opcodes 0xC to 0xF do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 1 | Interrupt request, sets pending bit |
| mem_addr_o | output | 12 | Address bus (address register) |
| mem_wdata_o | output | 16 | Write-data bus (buffer register) |
| mem_rdata_i | input | 16 | Read-data bus, valid one cycle after read strobe |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| halted_o | output | 1 | Sequencer stopped by HALT |

## Verification
The bench targets the flag corners: signed overflow on both add and subtract, carry out of 0xFFFF, borrow, and a zero result from AND. A design with swapped carry polarity or overflow terms stores a wrong status word. A compare that wrote back would change the stored accumulator. A test checks that loads and moves leave the flags alone, even when a loaded value is negative. The interrupt test expects the return address saved before the pending bit is cleared, and the interrupted program resuming with its next instruction. A design that skipped the increment or re-ran the instruction would produce a wrong final sum. After a halt, an interrupt pulse must not restart fetching.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_HALT = 4'h0,
    OP_LOAD = 4'h1,
    OP_STORE = 4'h2,
    OP_ADD = 4'h3,
    OP_SUB = 4'h4,
    OP_AND = 4'h5,
    OP_OR = 4'h6,
    OP_CMP = 4'h7,
    OP_JMP = 4'h8,
    OP_LDI = 4'h9,
    OP_JMPI = 4'hA,
    OP_MOVS = 4'hB,
    OP_NOP0 = 4'hC,
    OP_NOP1 = 4'hD,
    OP_NOP2 = 4'hE,
    OP_NOP3 = 4'hF
  } opcode_t;

  typedef enum logic [3:0] {
    S_FETCH,
    S_FWAIT,
    S_FCAP,
    S_FLOAD,
    S_DECODE,
    S_EWAIT,
    S_ECAP,
    S_EXEC,
    S_EWR,
    S_INT,
    S_IWR,
    S_HALT
  } seq_state_t;

  typedef struct packed {
    logic v;
    logic c;
    logic z;
    logic n;
  } alu_flags_t;

  function automatic logic needs_operand_read(opcode_t op);
    case (op)
      OP_LOAD, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_CMP, OP_JMPI: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  opcode_t             op,
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  output logic [DATA_W-1:0]   res,
  output alu_flags_t          flags
);

  logic [DATA_W:0] sum_w;
  logic [DATA_W:0] dif_w;

  always_comb begin
    sum_w = {1'b0, a} + {1'b0, b};
    dif_w = {1'b0, a} - {1'b0, b};
    res = '0;
    flags = '0;
    case (op)
      OP_ADD: begin
        res = sum_w[DATA_W-1:0];
        flags.c = sum_w[DATA_W];
        flags.v = (a[DATA_W-1] == b[DATA_W-1]) && (res[DATA_W-1] != a[DATA_W-1]);
      end
      OP_SUB, OP_CMP: begin
        res = dif_w[DATA_W-1:0];
        flags.c = dif_w[DATA_W];
        flags.v = (a[DATA_W-1] != b[DATA_W-1]) && (res[DATA_W-1] != a[DATA_W-1]);
      end
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      default: res = '0;
    endcase
    flags.z = (res == '0);
    flags.n = res[DATA_W-1];
  end

endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_cpu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  opcode_t    op,
  input  logic       int_pend,
  output seq_state_t state
);

  seq_state_t state_n;

  always_comb begin
    state_n = state;
    case (state)
      S_FETCH:  state_n = S_FWAIT;
      S_FWAIT:  state_n = S_FCAP;
      S_FCAP:   state_n = S_FLOAD;
      S_FLOAD:  state_n = S_DECODE;
      S_DECODE: begin
        if (op == OP_HALT)               state_n = S_HALT;
        else if (op == OP_STORE)         state_n = S_EWR;
        else if (needs_operand_read(op)) state_n = S_EWAIT;
        else                             state_n = S_INT;
      end
      S_EWAIT:  state_n = S_ECAP;
      S_ECAP:   state_n = S_EXEC;
      S_EXEC:   state_n = S_INT;
      S_EWR:    state_n = S_INT;
      S_INT:    state_n = int_pend ? S_IWR : S_FETCH;
      S_IWR:    state_n = S_FETCH;
      S_HALT:   state_n = S_HALT;
      default:  state_n = S_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_FETCH;
    else     state <= state_n;
  end

  // R11: once stopped the sequencer never leaves the halt state
  p_halt_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (state == S_HALT) |=> (state == S_HALT));

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] VEC_ADDR  = 12'h040,
  parameter logic [ADDR_W-1:0] SAVE_ADDR = 12'h0FF
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      irq_i,
  output logic [ADDR_W-1:0]         mem_addr_o,
  output logic [OP_W+ADDR_W-1:0]    mem_wdata_o,
  input  logic [OP_W+ADDR_W-1:0]    mem_rdata_i,
  output logic                      mem_rd_o,
  output logic                      mem_wr_o,
  output logic                      halted_o
);

  localparam int DATA_W = OP_W + ADDR_W;
  localparam int SR_W   = 5;

  seq_state_t          state;
  logic [ADDR_W-1:0]   pc;
  logic [DATA_W-1:0]   acc;
  logic [DATA_W-1:0]   cir;
  logic [ADDR_W-1:0]   mar;
  logic [DATA_W-1:0]   mbr;
  alu_flags_t          flags;
  logic                pend;
  logic                rd_q;
  logic                wr_q;
  opcode_t             op;
  logic [ADDR_W-1:0]   operand;
  logic [DATA_W-1:0]   alu_res;
  alu_flags_t          alu_flags;
  logic [DATA_W-1:0]   sr_word;
  logic [DATA_W-1:0]   operand_ext;
  logic [DATA_W-1:0]   pc_ext;

  assign op          = opcode_t'(cir[DATA_W-1:ADDR_W]);
  assign operand     = cir[ADDR_W-1:0];
  assign operand_ext = {{OP_W{1'b0}}, operand};
  assign pc_ext      = {{OP_W{1'b0}}, pc};
  assign sr_word     = {{(DATA_W-SR_W){1'b0}}, pend, flags};

  acc_cpu_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .int_pend (pend),
    .state    (state)
  );

  acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
    .op    (op),
    .a     (acc),
    .b     (mbr),
    .res   (alu_res),
    .flags (alu_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      acc   <= '0;
      cir   <= '0;
      mar   <= '0;
      mbr   <= '0;
      flags <= '0;
      rd_q  <= 1'b0;
      wr_q  <= 1'b0;
    end else begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
      case (state)
        S_FETCH: begin
          mar  <= pc;
          rd_q <= 1'b1;
        end
        S_FCAP: mbr <= mem_rdata_i;
        S_FLOAD: begin
          cir <= mbr;
          pc  <= pc + 1'b1;
        end
        S_DECODE: begin
          case (op)
            OP_LDI:  acc <= operand_ext;
            OP_MOVS: acc <= sr_word;
            OP_JMP:  pc  <= operand;
            OP_STORE: begin
              mar  <= operand;
              mbr  <= acc;
              wr_q <= 1'b1;
            end
            default: begin
              if (needs_operand_read(op)) begin
                mar  <= operand;
                rd_q <= 1'b1;
              end
            end
          endcase
        end
        S_ECAP: mbr <= mem_rdata_i;
        S_EXEC: begin
          case (op)
            OP_LOAD: acc <= mbr;
            OP_JMPI: pc  <= mbr[ADDR_W-1:0];
            OP_ADD, OP_SUB, OP_AND, OP_OR: begin
              acc   <= alu_res;
              flags <= alu_flags;
            end
            OP_CMP: flags <= alu_flags;
            default: ;
          endcase
        end
        S_INT: begin
          if (pend) begin
            mar  <= SAVE_ADDR;
            mbr  <= pc_ext;
            wr_q <= 1'b1;
            pc   <= VEC_ADDR;
          end
        end
        default: ;
      endcase
    end
  end

  // Pending bit: a request sets it, interrupt entry clears it
  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= irq_i | (pend & (state != S_INT));
  end

  assign mem_addr_o  = mar;
  assign mem_wdata_o = mbr;
  assign mem_rd_o    = rd_q;
  assign mem_wr_o    = wr_q;
  assign halted_o    = (state == S_HALT);

  p_rdwr_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_o && mem_wr_o));

  p_rd_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    mem_rd_o |=> !mem_rd_o);

  p_pc_inc_r2: assert property (@(posedge clk) disable iff (rst)
    (state == S_FLOAD) |=> (pc == $past(pc) + 1'b1));

  p_cmp_keeps_acc_r7: assert property (@(posedge clk) disable iff (rst)
    (state == S_EXEC && op == OP_CMP) |=> $stable(acc));

  p_int_entry_r10: assert property (@(posedge clk) disable iff (rst)
    (state == S_INT && pend) |=> (pc == VEC_ADDR && mem_wr_o && mem_addr_o == SAVE_ADDR));

  p_int_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (state == S_INT && pend && !irq_i) |=> !pend);

  p_halt_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    halted_o |-> (!mem_rd_o && !mem_wr_o));

endmodule

// File: tb/acc_cpu_core_tb.sv
module acc_cpu_core_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N_ALU = 11;
  localparam int WATCHDOG = 100000;

  // {opcode, a, b, expected acc, expected status word}
  localparam logic [79:0] ALU_TAB [N_ALU] = '{
    {16'h0003, 16'h0001, 16'h0002, 16'h0003, 16'h0000},
    {16'h0003, 16'hFFFF, 16'h0001, 16'h0000, 16'h0006},
    {16'h0003, 16'h7FFF, 16'h0001, 16'h8000, 16'h0009},
    {16'h0004, 16'h0005, 16'h0003, 16'h0002, 16'h0000},
    {16'h0004, 16'h0003, 16'h0005, 16'hFFFE, 16'h0005},
    {16'h0004, 16'h8000, 16'h0001, 16'h7FFF, 16'h0008},
    {16'h0005, 16'hF0F0, 16'h0FF0, 16'h00F0, 16'h0000},
    {16'h0005, 16'hF000, 16'h0FFF, 16'h0000, 16'h0002},
    {16'h0006, 16'h8000, 16'h0001, 16'h8001, 16'h0001},
    {16'h0007, 16'h0007, 16'h0007, 16'h0007, 16'h0002},
    {16'h0007, 16'h0002, 16'h0009, 16'h0002, 16'h0005}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq = 1'b0;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        mem_rd;
  logic        mem_wr;
  logic        halted;

  logic [15:0] mem [256];
  int          n_tests = 0;
  int          n_fail = 0;
  int          rd_cnt = 0;
  int          wr_cnt = 0;
  int          cycles = 0;
  logic        first_rd_seen = 1'b0;
  logic [11:0] first_rd_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_cpu_core dut_i (
    .clk         (clk),
    .rst         (rst),
    .irq_i       (irq),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .mem_rd_o    (mem_rd),
    .mem_wr_o    (mem_wr),
    .halted_o    (halted)
  );

  // Synchronous single-port memory model
  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst) begin
      if (mem_rd) rd_cnt <= rd_cnt + 1;
      if (mem_wr) wr_cnt <= wr_cnt + 1;
      if (mem_rd && !first_rd_seen) begin
        first_rd_seen <= 1'b1;
        first_rd_addr <= mem_addr;
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > WATCHDOG) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] a);
    return {op, a};
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst = 1'b1;
    irq = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic release_reset();
    rd_cnt = 0;
    wr_cnt = 0;
    first_rd_seen = 1'b0;
    rst = 1'b0;
  endtask

  task automatic wait_halt(input string req);
    int t;
    t = 0;
    while (!halted && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk(req, {15'b0, halted}, 16'h0001);
  endtask

  initial begin
    // Reset state (R1)
    clear_mem();
    mem[0] = ins(4'hB, 12'h000);
    mem[1] = ins(4'h2, 12'h0A0);
    hold_reset();
    chk("R1 rd low in reset", {15'b0, mem_rd}, 16'h0000);
    chk("R1 wr low in reset", {15'b0, mem_wr}, 16'h0000);
    chk("R1 halted low in reset", {15'b0, halted}, 16'h0000);
    release_reset();
    wait_halt("R11 halt reached");
    chk("R1 first fetch at 0", {4'b0, first_rd_addr}, 16'h0000);
    chk("R1 flags cleared", mem[8'hA0], 16'h0000);

    // ALU table walk (R5 R6 R7 R3 R2 R4)
    for (int k = 0; k < N_ALU; k++) begin
      logic [79:0] e;
      e = ALU_TAB[k];
      clear_mem();
      mem[0] = ins(4'h1, 12'h080);
      mem[1] = ins(e[67:64], 12'h081);
      mem[2] = ins(4'h2, 12'h082);
      mem[3] = ins(4'hB, 12'h000);
      mem[4] = ins(4'h2, 12'h083);
      mem[5] = ins(4'h0, 12'h000);
      mem[8'h80] = e[63:48];
      mem[8'h81] = e[47:32];
      hold_reset();
      release_reset();
      wait_halt("R11 halt after alu program");
      chk($sformatf("R5 R7 acc result case %0d", k), mem[8'h82], e[31:16]);
      chk($sformatf("R6 status word case %0d", k), mem[8'h83], e[15:0]);
      if (k == 0) begin
        chk("R3 R2 read strobes", rd_cnt[15:0], 16'd8);
        chk("R4 write strobes", wr_cnt[15:0], 16'd2);
      end
    end

    // Jumps, immediate, no-op opcode, flags untouched by LOAD/MOVS (R8 R9 R12)
    clear_mem();
    mem[0]  = ins(4'h9, 12'h005);
    mem[1]  = ins(4'hF, 12'h123);
    mem[2]  = ins(4'h8, 12'h004);
    mem[3]  = ins(4'h9, 12'h077);
    mem[4]  = ins(4'h2, 12'h090);
    mem[5]  = ins(4'hA, 12'h094);
    mem[6]  = ins(4'h9, 12'h066);
    mem[7]  = ins(4'h0, 12'h000);
    mem[8]  = ins(4'h1, 12'h092);
    mem[9]  = ins(4'hB, 12'h000);
    mem[10] = ins(4'h2, 12'h093);
    mem[11] = ins(4'h0, 12'h000);
    mem[8'h92] = 16'h8000;
    mem[8'h94] = 16'hF008;
    hold_reset();
    release_reset();
    wait_halt("R11 halt after jump program");
    chk("R9 R12 JMP skipped word 3, NOP harmless", mem[8'h90], 16'h0005);
    chk("R8 LOAD negative leaves flags clear", mem[8'h93], 16'h0000);

    // Interrupt entry and return (R10)
    clear_mem();
    mem[0] = ins(4'h9, 12'h001);
    mem[1] = ins(4'h3, 12'h0A0);
    mem[2] = ins(4'h2, 12'h0A1);
    mem[3] = ins(4'h0, 12'h000);
    mem[8'h40] = ins(4'h9, 12'h0AB);
    mem[8'h41] = ins(4'h2, 12'h0A2);
    mem[8'h42] = ins(4'hB, 12'h000);
    mem[8'h43] = ins(4'h2, 12'h0A3);
    mem[8'h44] = ins(4'h9, 12'h0AB);
    mem[8'h45] = ins(4'hA, 12'h0FF);
    mem[8'hA0] = 16'h0001;
    hold_reset();
    release_reset();
    @(negedge clk);
    irq = 1'b1;
    @(negedge clk);
    irq = 1'b0;
    wait_halt("R11 halt after interrupt program");
    chk("R10 saved return address", mem[8'hFF], 16'h0001);
    chk("R10 handler ran at vector", mem[8'hA2], 16'h00AB);
    chk("R10 pending cleared on entry", mem[8'hA3], 16'h0000);
    chk("R10 R9 resumed after return", mem[8'hA1], 16'h00AC);

    // Halt is final, interrupts ignored (R11)
    rd_cnt = 0;
    wr_cnt = 0;
    @(negedge clk);
    irq = 1'b1;
    @(negedge clk);
    irq = 1'b0;
    repeat (40) @(negedge clk);
    chk("R11 no reads after halt", rd_cnt[15:0], 16'd0);
    chk("R11 no writes after halt", wr_cnt[15:0], 16'd0);
    chk("R11 still halted", {15'b0, halted}, 16'h0001);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule